// File: doc/BRIEF.md
# Partitioned Slot Allocator

This block owns the occupancy flags of a fixed pool of message buffers. An agent asks for a slot and says which direction the buffer is for: receive or transmit. In the same cycle, the block answers with the index of the lowest free slot it may use, or with a failure flag. The granted slot is marked busy at the next clock edge. A separate port returns a slot to the pool by index. The buffer memory itself lives elsewhere and is addressed with the granted index.

The pool is split by direction. Transmit buffers may only come from the upper three quarters of the pool. Receive buffers may come from anywhere. The bottom quarter therefore stays reachable for incoming responses even when outgoing traffic has filled everything it is allowed to touch. Without this split, every buffer could end up holding an unanswered outgoing request, and no response could ever be received.

The test-and-set happens in a single cycle, so one slot is never handed out twice. An occupancy count output makes leaks visible.

Top module: `msg_slot_alloc`

## Requirements
- R1: A transmit request (`alloc_tx_i`=1) is only ever granted an index in the range POOL_SIZE/4 to POOL_SIZE-1. With the default of 64, that range is 16..63.
- R2: A receive request (`alloc_tx_i`=0) may be granted any index from 0 to POOL_SIZE-1, including the upper range once the lower quarter is full.
- R3: The granted index is the lowest free slot inside the allowed range.
- R4: A granted slot is busy from the next clock edge. It is not granted again until it has been released.
- R5: When no slot in the allowed range is free, `alloc_fail_o` is high, `alloc_ok_o` is low, and no flag or count changes.
- R6: A release makes its slot free from the next edge. Releasing a slot that is already free has no effect.
- R7: When a release and a request arrive in the same cycle, the release is applied first. The released slot can therefore be granted in that same cycle.
- R8: `used_cnt_o` always equals the number of busy slots.
- R9: After reset every slot is free and `used_cnt_o` is 0.
- R10: While `alloc_req_i` is low, `alloc_ok_o` and `alloc_fail_o` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Allocation request |
| alloc_tx_i | input | 1 | Category of the request: 1 for transmit, 0 for receive |
| alloc_ok_o | output | 1 | Request granted this cycle |
| alloc_fail_o | output | 1 | Request refused: no free slot in the allowed range |
| alloc_idx_o | output | $clog2(POOL_SIZE) | Granted slot index, valid with `alloc_ok_o` |
| rel_i | input | 1 | Release strobe |
| rel_idx_i | input | $clog2(POOL_SIZE) | Index of the slot to release |
| used_cnt_o | output | $clog2(POOL_SIZE+1) | Number of busy slots |

## Verification
A bound checker keeps its own shadow of the flags, driven only from port events. Against that shadow it checks, every cycle, that:
- a grant goes to a slot that is free after the same-cycle release;
- no lower free slot in the window was passed over;
- a transmit grant never lands in the lowest quarter;
- a refusal happens only when the window is truly full;
- the count matches the shadow.

Only the bench scenarios show the rest:
- the window boundary in full;
- exhaustion of each range in turn;
- a receive request spilling into the upper range;
- re-grant of a slot released in the same cycle;
- a redundant release;
- recovery from a mid-run reset.

// File: rtl/msa_pkg.sv
package msa_pkg;
  typedef enum logic {
    CAT_RX = 1'b0,
    CAT_TX = 1'b1
  } alloc_cat_e;
endpackage

// File: rtl/msa_first_free.sv
// Lowest set bit of a candidate vector.
module msa_first_free #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     cand_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/msa_flag_bank.sv
// Per-slot used flags; clear is applied ahead of set.
module msa_flag_bank #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic             set_en_i,
  input  logic [IDX_W-1:0] set_idx_i,
  output logic [N-1:0]     used_o,
  output logic [N-1:0]     eff_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic flag_q;
    logic clr_hit, set_hit;
    assign clr_hit  = clr_en_i && (clr_idx_i == IDX_W'(g));
    assign set_hit  = set_en_i && (set_idx_i == IDX_W'(g));
    assign eff_o[g] = flag_q && !clr_hit;
    assign used_o[g] = flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= eff_o[g] || set_hit;
    end
  end
endmodule

// File: rtl/msg_slot_alloc.sv
module msg_slot_alloc #(
  parameter int POOL_SIZE = 64,
  localparam int IDX_W    = $clog2(POOL_SIZE),
  localparam int CNT_W    = $clog2(POOL_SIZE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_req_i,
  input  logic             alloc_tx_i,
  output logic             alloc_ok_o,
  output logic             alloc_fail_o,
  output logic [IDX_W-1:0] alloc_idx_o,
  input  logic             rel_i,
  input  logic [IDX_W-1:0] rel_idx_i,
  output logic [CNT_W-1:0] used_cnt_o
);
  import msa_pkg::*;

  localparam int QUARTER = POOL_SIZE / 4;
  localparam logic [POOL_SIZE-1:0] TX_WIN =
    {{(POOL_SIZE - QUARTER){1'b1}}, {QUARTER{1'b0}}};

  initial begin
    if (POOL_SIZE % 4 != 0 || POOL_SIZE < 4)
      $error("POOL_SIZE must be a positive multiple of 4");
  end

  alloc_cat_e cat;
  logic [POOL_SIZE-1:0] used_q, used_eff, window, cand;
  logic found, grant, rel_hit;
  logic [IDX_W-1:0] first_idx;
  logic [CNT_W-1:0] cnt_q;

  assign cat    = alloc_cat_e'(alloc_tx_i);
  assign window = (cat == CAT_TX) ? TX_WIN : '1;
  assign cand   = ~used_eff & window;

  msa_first_free #(.N(POOL_SIZE), .IDX_W(IDX_W)) u_find (
    .cand_i (cand),
    .found_o(found),
    .idx_o  (first_idx)
  );

  assign grant = alloc_req_i && found;

  msa_flag_bank #(.N(POOL_SIZE), .IDX_W(IDX_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_en_i (rel_i),
    .clr_idx_i(rel_idx_i),
    .set_en_i (grant),
    .set_idx_i(first_idx),
    .used_o   (used_q),
    .eff_o    (used_eff)
  );

  assign rel_hit = rel_i && used_q[rel_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q - CNT_W'(rel_hit) + CNT_W'(grant);
  end

  assign alloc_ok_o   = grant;
  assign alloc_fail_o = alloc_req_i && !found;
  assign alloc_idx_o  = first_idx;
  assign used_cnt_o   = cnt_q;
endmodule

// File: rtl/msg_slot_alloc_checker.sv
module msg_slot_alloc_checker #(
  parameter int POOL_SIZE = 64,
  localparam int IDX_W    = $clog2(POOL_SIZE),
  localparam int CNT_W    = $clog2(POOL_SIZE + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_req_i,
  input logic             alloc_tx_i,
  input logic             alloc_ok_o,
  input logic             alloc_fail_o,
  input logic [IDX_W-1:0] alloc_idx_o,
  input logic             rel_i,
  input logic [IDX_W-1:0] rel_idx_i,
  input logic [CNT_W-1:0] used_cnt_o
);
  localparam int QUARTER = POOL_SIZE / 4;
  localparam logic [POOL_SIZE-1:0] TX_WIN =
    {{(POOL_SIZE - QUARTER){1'b1}}, {QUARTER{1'b0}}};

  logic [POOL_SIZE-1:0] shadow_q, shadow_eff, rel_mask, win, below;

  assign rel_mask   = rel_i ? (POOL_SIZE'(1) << rel_idx_i) : '0;
  assign shadow_eff = shadow_q & ~rel_mask;
  assign win        = alloc_tx_i ? TX_WIN : '1;
  assign below      = (POOL_SIZE'(1) << alloc_idx_o) - POOL_SIZE'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else shadow_q <= shadow_eff | (alloc_ok_o ? (POOL_SIZE'(1) << alloc_idx_o) : '0);
  end

  a_r1_tx_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ok_o && alloc_tx_i |-> int'(alloc_idx_o) >= QUARTER);
  a_r3_lowest_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ok_o |-> (~shadow_eff & win & below) == '0);
  a_r4_no_double_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ok_o |-> !shadow_eff[alloc_idx_o]);
  a_r5_fail_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fail_o |-> (~shadow_eff & win) == '0);
  a_r5_fail_holds_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fail_o && !rel_i |=> $stable(used_cnt_o));
  a_r8_count_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(used_cnt_o) == $countones(shadow_q));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_req_i |-> !alloc_ok_o && !alloc_fail_o);
  a_r10_one_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_req_i |-> $onehot({alloc_ok_o, alloc_fail_o}));
endmodule

bind msg_slot_alloc msg_slot_alloc_checker #(.POOL_SIZE(POOL_SIZE)) u_chk (.*);

// File: tb/msg_slot_alloc_bench.sv
module msg_slot_alloc_bench;
  localparam int P = 64;
  localparam int IW = $clog2(P);
  localparam int CW = $clog2(P + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, tx = 1'b0, rel = 1'b0;
  logic [IW-1:0] rel_idx = '0;
  logic ok, fail;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msg_slot_alloc #(.POOL_SIZE(P)) u_msg_slot_alloc (
    .clk_i(clk), .rst_ni(rst_n), .alloc_req_i(req), .alloc_tx_i(tx),
    .alloc_ok_o(ok), .alloc_fail_o(fail), .alloc_idx_o(idx),
    .rel_i(rel), .rel_idx_i(rel_idx), .used_cnt_o(cnt));

  // {req, tx, rel, rel_idx[7:0], exp_ok, exp_fail, exp_idx[7:0], exp_cnt_after[7:0]}
  localparam logic [28:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 1'b0, 8'd0,  8'd1},  // R2 rx from 0
    {1'b1, 1'b1, 1'b0, 8'd0,  1'b1, 1'b0, 8'd16, 8'd2},  // R1 tx from quarter
    {1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 1'b0, 8'd1,  8'd3},  // R3
    {1'b1, 1'b1, 1'b0, 8'd0,  1'b1, 1'b0, 8'd17, 8'd4},  // R4
    {1'b0, 1'b0, 1'b1, 8'd0,  1'b0, 1'b0, 8'd0,  8'd3},  // R6 R10
    {1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 1'b0, 8'd0,  8'd4},  // R6 slot reusable
    {1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 1'b0, 8'd1,  8'd4},  // R7
    {1'b1, 1'b1, 1'b1, 8'd16, 1'b1, 1'b0, 8'd16, 8'd4},  // R7 tx
    {1'b0, 1'b0, 1'b1, 8'd5,  1'b0, 1'b0, 8'd0,  8'd4},  // R6 free slot release
    {1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 1'b0, 8'd2,  8'd5}   // R3
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive after negedge, sample grant before posedge, sample count after it.
  task automatic step(input logic r, input logic t, input logic rl, input int ri,
                      output logic s_ok, output logic s_fail, output int s_idx,
                      output int s_cnt);
    @(negedge clk);
    req = r; tx = t; rel = rl; rel_idx = IW'(ri);
    #3;
    s_ok = ok; s_fail = fail; s_idx = int'(idx);
    @(posedge clk);
    #1;
    s_cnt = int'(cnt);
    req = 1'b0; rel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic s_ok, s_fail;
    int s_idx, s_cnt;
    #1;
    check("R9 reset count", 32'(cnt), 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R9 count after reset", 32'(cnt), 0);

    for (int v = 0; v < 10; v++) begin
      logic [28:0] e;
      e = VEC[v];
      step(e[28], e[27], e[26], int'(e[25:18]), s_ok, s_fail, s_idx, s_cnt);
      check($sformatf("R3 vec%0d ok", v), 32'(s_ok), 32'(e[17]));
      check($sformatf("R10 vec%0d fail", v), 32'(s_fail), 32'(e[16]));
      if (e[17]) check($sformatf("R3 vec%0d idx", v), s_idx, 32'(e[15:8]));
      check($sformatf("R8 vec%0d cnt", v), s_cnt, 32'(e[7:0]));
    end

    // busy: 0,1,2,16,17 -> tx fills 18..63
    for (int i = 18; i < P; i++) begin
      step(1, 1, 0, 0, s_ok, s_fail, s_idx, s_cnt);
      check("R1 tx fill idx", s_idx, i);
    end
    check("R8 count after tx fill", s_cnt, 51);
    step(1, 1, 0, 0, s_ok, s_fail, s_idx, s_cnt);
    check("R5 tx fail", 32'(s_fail), 1);
    check("R5 tx no ok", 32'(s_ok), 0);
    check("R5 count held", s_cnt, 51);
    step(1, 0, 0, 0, s_ok, s_fail, s_idx, s_cnt);
    check("R2 rx still served idx", s_idx, 3);
    for (int i = 4; i < P / 4; i++) begin
      step(1, 0, 0, 0, s_ok, s_fail, s_idx, s_cnt);
      check("R2 rx fill idx", s_idx, i);
    end
    check("R8 full count", s_cnt, 64);
    step(1, 0, 0, 0, s_ok, s_fail, s_idx, s_cnt);
    check("R5 rx fail when full", 32'(s_fail), 1);
    check("R5 count held full", s_cnt, 64);

    // R2: free an upper slot, rx takes it once lower quarter is full
    step(0, 0, 1, 40, s_ok, s_fail, s_idx, s_cnt);
    step(1, 0, 0, 0, s_ok, s_fail, s_idx, s_cnt);
    check("R2 rx spills to upper", s_idx, 40);
    // R4: slot 40 not given twice
    step(1, 1, 0, 0, s_ok, s_fail, s_idx, s_cnt);
    check("R4 no double grant", 32'(s_fail), 1);
    // R1: free a low slot, tx must still fail
    step(0, 0, 1, 7, s_ok, s_fail, s_idx, s_cnt);
    step(1, 1, 0, 0, s_ok, s_fail, s_idx, s_cnt);
    check("R1 tx ignores low slot", 32'(s_fail), 1);
    check("R1 count", s_cnt, 63);

    for (int i = 0; i < P; i++) step(0, 0, 1, i, s_ok, s_fail, s_idx, s_cnt);
    check("R6 all released", s_cnt, 0);

    step(1, 1, 0, 0, s_ok, s_fail, s_idx, s_cnt);
    step(1, 0, 0, 0, s_ok, s_fail, s_idx, s_cnt);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async reset count", 32'(cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 0, 0, s_ok, s_fail, s_idx, s_cnt);
    check("R9 idx0 after reset", s_idx, 0);
    check("R9 count after reset alloc", s_cnt, 1);

    finish_run();
  end
endmodule